// File: doc/BRIEF.md
# Edge False-Trigger Statistics Monitor

This block grades the quality of a conditioned digital crossing stream. It receives a single-clock pulse for every detected edge and a single-clock pulse that marks each reference cycle. Once it is armed, it counts reference cycles and observed edges until a programmed number of cycles has elapsed. It then reports how many edges exceeded the programmed per-cycle expectation and whether that excess fits a per-cycle budget. A shortfall of edges is raised on a separate flag and is never turned into a false-trigger figure.

While the window is open, the clock distance between each pair of consecutive edges goes into one of a set of power-of-two-wide bins, which together form a jitter histogram. The bins are read through an address/data port. The bin width and the number of recorded intervals are reported beside the histogram. The configuration is captured only while the monitor is idle, so the rules cannot shift partway through a count.

The budget is written as allowed excess edges per 2^SCALE_LOG2 cycles. With the default of 20, this is roughly one per million. The check multiplies both sides instead of dividing.

Top module: `edge_stat_monitor`

## Requirements
- R1: `cfg_wr` captures window length, per-cycle expectation, limit and bin shift only while `busy` is low. A write while `busy` is high is ignored, and the running window uses the values it started with.
- R2: A `start` pulse while idle raises `busy` on the next clock and zeroes the counts, the sample count and every histogram bin. Edge or marker pulses in the same clock as `start` are not counted. A `start` while `busy` is high has no effect.
- R3: While `busy` is high, each `edge_pulse` adds one to `edge_count` and each `cycle_mark` adds one to `cycle_count`. The marker that brings `cycle_count` to the window length drops `busy` and raises `done` on that clock, and an edge in the same clock is still counted. A window length of 0 acts as 1. `done` stays high until the next accepted `start` or a `clear`.
- R4: With E = per-cycle expectation × `cycle_count`, `excess_count` = `edge_count` − E when `edge_count` ≥ E. Otherwise `excess_count` is 0 and `missing` is 1.
- R5: `pass` = `done` AND NOT `missing` AND (`excess_count` × 2^SCALE_LOG2 ≤ `cycle_count` × limit). The comparison is inclusive at equality.
- R6: For every edge inside the window except the first, the interval is the number of clocks since the previous edge, saturating at 2^GAP_W−1. Bin (interval >> shift) is incremented. An index of NBINS−1 or more goes to the last bin, NBINS−1.
- R7: A bin at 2^BIN_W−1 stays there and does not wrap.
- R8: `hist_samples` counts the intervals recorded in the window, which is `edge_count` − 1 when there is at least one edge. `bin_width` equals 2^shift clocks.
- R9: A `clear` pulse, at any time, drives `busy`, `done`, both counts, the sample count and every bin to zero on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Arm a new observation window |
| clear | input | 1 | Abort and zero all statistics |
| cfg_wr | input | 1 | Capture the configuration fields (idle only) |
| cfg_window | input | CYC_W | Window length in reference cycles |
| cfg_per_cycle | input | EXP_W | Valid edges expected per cycle |
| cfg_limit | input | LIM_W | Allowed excess edges per 2^SCALE_LOG2 cycles |
| cfg_bin_shift | input | SH_W | log2 of histogram bin width in clocks |
| edge_pulse | input | 1 | Synchronized one-clock edge event |
| cycle_mark | input | 1 | One-clock reference cycle marker |
| busy | output | 1 | Window open |
| done | output | 1 | Window completed |
| cycle_count | output | CYC_W | Cycles counted |
| edge_count | output | EDGE_W | Edges counted |
| excess_count | output | EDGE_W | Edges beyond expectation |
| missing | output | 1 | Fewer edges than expected |
| pass | output | 1 | Completed window within budget |
| hist_rd_addr | input | log2(NBINS) | Histogram bin select |
| hist_rd_data | output | BIN_W | Selected bin value |
| hist_samples | output | EDGE_W | Intervals recorded |
| bin_width | output | 2^SH_W | Bin width in clocks |

## Verification
A clean pattern with exactly the expected number of evenly spaced edges shows that correct counting gives zero excess and lands every interval in one bin. A stream with a single chattering edge is run twice, with the limit at the equality point and one below it, which separates an inclusive comparison from an exclusive one. A stream with too few edges must raise the shortfall flag instead of a rate. A long burst of one-clock edges followed by a long gap exercises bin saturation and the overflow bin. Configuration writes and start pulses sent in the middle of a window, a clear in the middle of a window and a zero-length window each show that the control ignores what it must ignore.

// File: rtl/esm_pkg.sv
package esm_pkg;
  typedef logic [63:0] wide_t;

  // total edges a window should contain
  function automatic wide_t expected_edges(wide_t per_cycle, wide_t cycles);
    return per_cycle * cycles;
  endfunction

  // excess * 2^scale_log2 <= cycles * limit, division free
  function automatic logic budget_ok(wide_t excess, wide_t cycles, wide_t limit,
                                     int unsigned scale_log2);
    return (excess << scale_log2) <= (cycles * limit);
  endfunction

  // histogram bin for an interval, folding the tail into the last bin
  function automatic int unsigned bin_index(wide_t gap, int unsigned shift,
                                            int unsigned nbins);
    wide_t idx;
    idx = gap >> shift;
    if (idx >= wide_t'(nbins - 1)) return nbins - 1;
    return idx[31:0];
  endfunction
endpackage

// File: rtl/esm_window_ctrl.sv
module esm_window_ctrl #(
  parameter int CYC_W  = 20,
  parameter int EDGE_W = 24,
  parameter int EXP_W  = 4,
  parameter int LIM_W  = 16,
  parameter int SH_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              clear,
  input  logic              cfg_wr,
  input  logic [CYC_W-1:0]  cfg_window,
  input  logic [EXP_W-1:0]  cfg_per_cycle,
  input  logic [LIM_W-1:0]  cfg_limit,
  input  logic [SH_W-1:0]   cfg_bin_shift,
  input  logic              edge_pulse,
  input  logic              cycle_mark,
  output logic              busy,
  output logic              done,
  output logic              restart,
  output logic              take_edge,
  output logic              last_mark,
  output logic [CYC_W-1:0]  cycles,
  output logic [EDGE_W-1:0] edges,
  output logic [EXP_W-1:0]  per_cyc_q,
  output logic [LIM_W-1:0]  limit_q,
  output logic [SH_W-1:0]   shift_q
);
  logic [CYC_W-1:0] window_q;
  logic [CYC_W:0]   next_cycles;

  assign restart     = start && !busy && !clear;
  assign take_edge   = busy && edge_pulse && !clear;
  assign next_cycles = {1'b0, cycles} + 1'b1;
  assign last_mark   = busy && cycle_mark && !clear &&
                       (next_cycles >= {1'b0, window_q});

  // configuration is frozen while a window is open
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      window_q  <= '0;
      per_cyc_q <= '0;
      limit_q   <= '0;
      shift_q   <= '0;
    end else if (cfg_wr && !busy) begin
      window_q  <= cfg_window;
      per_cyc_q <= cfg_per_cycle;
      limit_q   <= cfg_limit;
      shift_q   <= cfg_bin_shift;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      cycles <= '0;
      edges  <= '0;
    end else if (restart) begin
      busy   <= 1'b1;
      done   <= 1'b0;
      cycles <= '0;
      edges  <= '0;
    end else if (busy) begin
      if (take_edge) edges <= edges + 1'b1;
      if (cycle_mark) cycles <= next_cycles[CYC_W-1:0];
      if (last_mark) begin
        busy <= 1'b0;
        done <= 1'b1;
      end
    end
  end

  assert_cfg_frozen_R1: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(window_q) && $stable(per_cyc_q) &&
                            $stable(limit_q) && $stable(shift_q));

  assert_done_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  assert_close_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && !$past(clear) |-> done);

  assert_clear_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !busy && !done && cycles == '0 && edges == '0);
endmodule

// File: rtl/esm_interval_hist.sv
module esm_interval_hist #(
  parameter int NBINS  = 16,
  parameter int BIN_W  = 8,
  parameter int GAP_W  = 16,
  parameter int SH_W   = 4,
  parameter int EDGE_W = 24,
  localparam int AW    = $clog2(NBINS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wipe,
  input  logic              take_edge,
  input  logic [SH_W-1:0]   shift,
  input  logic [AW-1:0]     rd_addr,
  output logic [BIN_W-1:0]  rd_data,
  output logic [EDGE_W-1:0] samples
);
  localparam logic [GAP_W-1:0] GAP_MAX = '1;
  localparam logic [BIN_W-1:0] BIN_MAX = '1;

  logic [GAP_W-1:0]       gap;
  logic                   have_prev;
  logic                   record;
  logic [AW-1:0]          sel;
  logic [NBINS*BIN_W-1:0] bins_flat;

  assign record = take_edge && have_prev;
  assign sel    = AW'(esm_pkg::bin_index(esm_pkg::wide_t'(gap), 32'(shift), NBINS));

  // clocks since the previous accepted edge
  always_ff @(posedge clk) begin
    if (!rst_n || wipe) begin
      gap       <= '0;
      have_prev <= 1'b0;
      samples   <= '0;
    end else if (take_edge) begin
      gap       <= GAP_W'(1);
      have_prev <= 1'b1;
      if (have_prev) samples <= samples + 1'b1;
    end else if (have_prev && gap != GAP_MAX) begin
      gap <= gap + 1'b1;
    end
  end

  for (genvar b = 0; b < NBINS; b++) begin : g_bin
    logic [BIN_W-1:0] cnt;
    always_ff @(posedge clk) begin
      if (!rst_n || wipe) cnt <= '0;
      else if (record && sel == AW'(b) && cnt != BIN_MAX) cnt <= cnt + 1'b1;
    end
    assign bins_flat[b*BIN_W +: BIN_W] = cnt;

    assert_bin_sat_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(cnt) == BIN_MAX && !$past(wipe) |-> cnt == BIN_MAX);
  end

  always_comb begin
    rd_data = '0;
    for (int b = 0; b < NBINS; b++)
      if (rd_addr == AW'(b)) rd_data = bins_flat[b*BIN_W +: BIN_W];
  end
endmodule

// File: rtl/esm_verdict.sv
module esm_verdict #(
  parameter int CYC_W      = 20,
  parameter int EDGE_W     = 24,
  parameter int EXP_W      = 4,
  parameter int LIM_W      = 16,
  parameter int SCALE_LOG2 = 20
) (
  input  logic              done,
  input  logic [CYC_W-1:0]  cycles,
  input  logic [EDGE_W-1:0] edges,
  input  logic [EXP_W-1:0]  per_cyc,
  input  logic [LIM_W-1:0]  limit,
  output logic [EDGE_W-1:0] excess,
  output logic              missing,
  output logic              pass
);
  esm_pkg::wide_t exp_w, edges_w, excess_w;

  assign exp_w    = esm_pkg::expected_edges(esm_pkg::wide_t'(per_cyc),
                                            esm_pkg::wide_t'(cycles));
  assign edges_w  = esm_pkg::wide_t'(edges);
  assign missing  = edges_w < exp_w;
  assign excess_w = missing ? '0 : (edges_w - exp_w);
  assign excess   = EDGE_W'(excess_w);
  assign pass     = done && !missing &&
                    esm_pkg::budget_ok(excess_w, esm_pkg::wide_t'(cycles),
                                       esm_pkg::wide_t'(limit), SCALE_LOG2);
endmodule

// File: rtl/edge_stat_monitor.sv
module edge_stat_monitor #(
  parameter int CYC_W      = 20,
  parameter int EDGE_W     = 24,
  parameter int EXP_W      = 4,
  parameter int LIM_W      = 16,
  parameter int SH_W       = 4,
  parameter int SCALE_LOG2 = 20,
  parameter int NBINS      = 16,
  parameter int BIN_W      = 8,
  parameter int GAP_W      = 16,
  localparam int AW        = $clog2(NBINS),
  localparam int BWW       = 1 << SH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              clear,
  input  logic              cfg_wr,
  input  logic [CYC_W-1:0]  cfg_window,
  input  logic [EXP_W-1:0]  cfg_per_cycle,
  input  logic [LIM_W-1:0]  cfg_limit,
  input  logic [SH_W-1:0]   cfg_bin_shift,
  input  logic              edge_pulse,
  input  logic              cycle_mark,
  output logic              busy,
  output logic              done,
  output logic [CYC_W-1:0]  cycle_count,
  output logic [EDGE_W-1:0] edge_count,
  output logic [EDGE_W-1:0] excess_count,
  output logic              missing,
  output logic              pass,
  input  logic [AW-1:0]     hist_rd_addr,
  output logic [BIN_W-1:0]  hist_rd_data,
  output logic [EDGE_W-1:0] hist_samples,
  output logic [BWW-1:0]    bin_width
);
  logic             restart, take_edge, last_mark, wipe;
  logic [EXP_W-1:0] per_cyc_q;
  logic [LIM_W-1:0] limit_q;
  logic [SH_W-1:0]  shift_q;

  assign wipe      = clear || restart;
  assign bin_width = BWW'(1) << shift_q;

  esm_window_ctrl #(.CYC_W(CYC_W), .EDGE_W(EDGE_W), .EXP_W(EXP_W),
                    .LIM_W(LIM_W), .SH_W(SH_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .clear(clear), .cfg_wr(cfg_wr),
    .cfg_window(cfg_window), .cfg_per_cycle(cfg_per_cycle),
    .cfg_limit(cfg_limit), .cfg_bin_shift(cfg_bin_shift),
    .edge_pulse(edge_pulse), .cycle_mark(cycle_mark),
    .busy(busy), .done(done), .restart(restart), .take_edge(take_edge),
    .last_mark(last_mark), .cycles(cycle_count), .edges(edge_count),
    .per_cyc_q(per_cyc_q), .limit_q(limit_q), .shift_q(shift_q));

  esm_interval_hist #(.NBINS(NBINS), .BIN_W(BIN_W), .GAP_W(GAP_W),
                      .SH_W(SH_W), .EDGE_W(EDGE_W)) u_hist (
    .clk(clk), .rst_n(rst_n), .wipe(wipe), .take_edge(take_edge),
    .shift(shift_q), .rd_addr(hist_rd_addr), .rd_data(hist_rd_data),
    .samples(hist_samples));

  esm_verdict #(.CYC_W(CYC_W), .EDGE_W(EDGE_W), .EXP_W(EXP_W),
                .LIM_W(LIM_W), .SCALE_LOG2(SCALE_LOG2)) u_verdict (
    .done(done), .cycles(cycle_count), .edges(edge_count),
    .per_cyc(per_cyc_q), .limit(limit_q),
    .excess(excess_count), .missing(missing), .pass(pass));

  // sample counter (histogram side) must trail the edge counter (window side) by one
  assert_samples_track_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_count == '0) ? (hist_samples == '0) : (hist_samples == edge_count - 1'b1));

  assert_window_close_R3: assert property (@(posedge clk) disable iff (!rst_n)
    last_mark |=> done && !busy);
endmodule

// File: tb/tb_edge_stat_monitor.sv
module tb_edge_stat_monitor;
  localparam int NB = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, clear = 1'b0, cfg_wr = 1'b0;
  logic [19:0] cfg_window = '0;
  logic [3:0]  cfg_per_cycle = '0;
  logic [15:0] cfg_limit = '0;
  logic [3:0]  cfg_bin_shift = '0;
  logic edge_pulse = 1'b0, cycle_mark = 1'b0;
  logic busy, done, missing, pass;
  logic [19:0] cycle_count;
  logic [23:0] edge_count, excess_count, hist_samples;
  logic [3:0]  hist_rd_addr = '0;
  logic [7:0]  hist_rd_data;
  logic [15:0] bin_width;

  edge_stat_monitor dut (
    .clk(clk), .rst_n(rst_n), .start(start), .clear(clear), .cfg_wr(cfg_wr),
    .cfg_window(cfg_window), .cfg_per_cycle(cfg_per_cycle),
    .cfg_limit(cfg_limit), .cfg_bin_shift(cfg_bin_shift),
    .edge_pulse(edge_pulse), .cycle_mark(cycle_mark),
    .busy(busy), .done(done), .cycle_count(cycle_count),
    .edge_count(edge_count), .excess_count(excess_count),
    .missing(missing), .pass(pass), .hist_rd_addr(hist_rd_addr),
    .hist_rd_data(hist_rd_data), .hist_samples(hist_samples),
    .bin_width(bin_width));

  always #10 clk = ~clk;

  int total = 0, fails = 0;

  task automatic chk(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference model
  bit m_busy, m_done, m_have, was_busy;
  longint m_cycles, m_edges, m_samples, m_gap;
  longint m_win, m_pc, m_lim, m_sh;
  int m_hist[NB];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_have = 0; m_cycles = 0; m_edges = 0;
      m_samples = 0; m_gap = 0; m_win = 0; m_pc = 0; m_lim = 0; m_sh = 0;
      foreach (m_hist[i]) m_hist[i] = 0;
    end else begin
      was_busy = m_busy;
      if (cfg_wr && !was_busy) begin
        m_win = cfg_window; m_pc = cfg_per_cycle; m_lim = cfg_limit; m_sh = cfg_bin_shift;
      end
      if (clear || (start && !was_busy)) begin
        m_busy = !clear; m_done = 0; m_cycles = 0; m_edges = 0;
        m_samples = 0; m_have = 0; m_gap = 0;
        foreach (m_hist[i]) m_hist[i] = 0;
      end else if (was_busy) begin
        if (edge_pulse) begin
          m_edges++;
          if (m_have) begin
            longint b = m_gap >> m_sh;
            if (b > NB - 1) b = NB - 1;
            if (m_hist[b] < 255) m_hist[b]++;
            m_samples++;
          end
          m_have = 1; m_gap = 1;
        end else if (m_have && m_gap < 65535) m_gap++;
        if (cycle_mark) begin
          m_cycles++;
          if (m_cycles >= m_win) begin m_busy = 0; m_done = 1; end
        end
      end
    end
  end

  // clock-by-clock comparison
  always @(negedge clk) begin
    if (rst_n) begin
      longint e_exp, e_exc;
      bit e_miss, e_pass;
      e_exp  = m_pc * m_cycles;
      e_miss = m_edges < e_exp;
      e_exc  = e_miss ? 0 : m_edges - e_exp;
      e_pass = m_done && !e_miss && ((e_exc << 20) <= m_cycles * m_lim);
      chk("R3 model busy", busy, m_busy);
      chk("R3 model done", done, m_done);
      chk("R3 model cycles", cycle_count, m_cycles);
      chk("R3 model edges", edge_count, m_edges);
      chk("R8 model samples", hist_samples, m_samples);
      chk("R4 model excess", excess_count, e_exc);
      chk("R4 model missing", missing, e_miss);
      chk("R5 model pass", pass, e_pass);
    end
  end

  task automatic step(bit e, bit m);
    edge_pulse = e; cycle_mark = m;
    @(negedge clk);
    edge_pulse = 0; cycle_mark = 0; start = 0; clear = 0; cfg_wr = 0;
  endtask

  task automatic configure(int win, int pc, int lim, int sh);
    cfg_window = 20'(win); cfg_per_cycle = 4'(pc);
    cfg_limit = 16'(lim); cfg_bin_shift = 4'(sh); cfg_wr = 1;
    step(0, 0);
  endtask

  // start clock carries an edge and a marker that must be ignored (R2)
  task automatic open_window();
    start = 1;
    step(1, 1);
  endtask

  task automatic cyc(int p, int ne, int sp);
    for (int k = 0; k < p; k++)
      step(k >= 1 && k < 1 + ne * sp && ((k - 1) % sp) == 0, k == p - 1);
  endtask

  task automatic bin_is(int idx, int exp, string tag);
    hist_rd_addr = 4'(idx);
    #1;
    chk(tag, hist_rd_data, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R3 reset busy", busy, 0);
    chk("R3 reset done", done, 0);
    chk("R3 reset edges", edge_count, 0);
    chk("R5 reset pass", pass, 0);

    // clean stream: 2 edges per 20-clock cycle
    configure(4, 2, 1, 2);
    open_window();
    repeat (4) cyc(20, 2, 10);
    chk("R3 clean done", done, 1);
    chk("R2 clean cycles exclude start clock", cycle_count, 4);
    chk("R3 clean edges", edge_count, 8);
    chk("R4 clean excess", excess_count, 0);
    chk("R5 clean pass", pass, 1);
    chk("R8 clean samples", hist_samples, 7);
    chk("R8 clean bin width", bin_width, 4);
    bin_is(2, 7, "R6 clean interval 10 bin 2");

    // one chattering edge, limit at equality point; cfg write mid-window ignored
    configure(32, 1, 32768, 0);
    open_window();
    cyc(10, 2, 2);
    cfg_per_cycle = 0; cfg_wr = 1;
    repeat (31) cyc(10, 1, 1);
    chk("R1 excess uses frozen expectation", excess_count, 1);
    chk("R5 equality passes", pass, 1);
    bin_is(2, 1, "R6 chatter bin 2");
    bin_is(8, 1, "R6 chatter bin 8");
    bin_is(10, 30, "R6 chatter bin 10");

    configure(32, 1, 32767, 0);
    open_window();
    cyc(10, 2, 2);
    repeat (31) cyc(10, 1, 1);
    chk("R5 one below equality fails", pass, 0);
    chk("R4 excess again", excess_count, 1);

    // too few edges
    configure(4, 2, 65535, 2);
    open_window();
    repeat (4) cyc(20, 1, 1);
    chk("R4 missing flag", missing, 1);
    chk("R4 missing excess zero", excess_count, 0);
    chk("R5 missing fails", pass, 0);

    // saturation, overflow bin, start while busy
    configure(1, 0, 65535, 0);
    open_window();
    repeat (300) step(1, 0);
    for (int i = 0; i < 40; i++) begin
      if (i == 20) start = 1;
      step(0, 0);
    end
    step(1, 1);
    chk("R2 start while busy ignored", edge_count, 301);
    bin_is(1, 255, "R7 bin saturates");
    bin_is(15, 1, "R6 overflow bin");
    chk("R8 samples unsaturated", hist_samples, 300);
    chk("R8 bin width shift 0", bin_width, 1);
    chk("R5 big excess fails", pass, 0);

    // clear mid-window, then zero-length window
    configure(4, 1, 65535, 0);
    open_window();
    repeat (5) step(1, 0);
    clear = 1;
    step(0, 0);
    chk("R9 clear busy", busy, 0);
    chk("R9 clear edges", edge_count, 0);
    chk("R9 clear samples", hist_samples, 0);
    bin_is(1, 0, "R9 clear bins");
    configure(0, 0, 0, 0);
    open_window();
    step(0, 1);
    chk("R3 zero window done", done, 1);
    chk("R3 zero window cycles", cycle_count, 1);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #4000000;
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule